// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches one bank of general-purpose inputs, up to eight pins, and raises one combined interrupt line to a host processor. Each pin has its own configuration: an enable bit, a mask bit, a trigger-type bit and a polarity bit. The type and polarity bits together pick one of four trigger modes: active-low level, active-high level, falling edge or rising edge.

Software reaches the configuration through a small APB-style register port. Each pin input passes through a two-flop synchroniser. An edge is found by comparing the synchronised value with the sample taken one cycle earlier. An edge that matches the configured mode on an enabled pin sets a sticky pending bit. That bit stays set until software writes a one to the pin's position in the acknowledge register. A level-mode pin reports its qualified input directly and has no latch.

The status register shows what software would service: pending AND enable AND NOT mask. The interrupt output is the OR of the status bits. A mask bit only hides the pin from status and from the interrupt output. The pending latch behind a masked pin is kept.

Top module: `gpirq_top`

## Requirements
- R1: After reset, every register reads zero, the status word reads zero and `irq_out` is low.
- R2: The enable (0x30), mask (0x34), trigger-type (0x38) and polarity (0x3c) registers are read/write in bits [NPIN-1:0]. Every read returns zero in bits [31:NPIN].
- R3: With type=1 and enable=1, a rising input sets the pin's pending bit when polarity=1, and a falling input sets it when polarity=0. The bit stays set and shows in status within three clock cycles of the input change.
- R4: With type=0 and enable=1, the pin's status follows the input when polarity=1 and the inverted input when polarity=0. A write to the acknowledge register has no effect on such a pin.
- R5: Writing a one to a bit of the acknowledge register (0x4c) clears that pin's edge-pending bit. Writing a zero to a bit leaves it unchanged. The acknowledge register reads zero.
- R6: Clearing a pin's enable bit clears its pending latch. Edges that occur while the pin is disabled are not recorded.
- R7: A mask bit of 1 removes the pin from status and from `irq_out` but keeps its pending latch. Clearing the mask bit makes the pin reappear.
- R8: The status register (0x40) reads pending AND enable AND NOT mask, and several bits may be set at once. `irq_out` is high exactly when the status is nonzero.
- R9: Reads of any other offset return zero. Writes to the status offset or to undefined offsets change nothing.
- R10: Switching a pin's type bit to 0 (level) discards its edge-pending latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a register transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while psel is high and pwrite is low |
| pin_in | input | NPIN | Asynchronous pin inputs |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A pending latch that is wrongly set or wrongly lost shows in the status word and on `irq_out`. An edge on an input appears in both no later than the third clock edge after the input changes, and a level input appears after the second. A latch that survives a disable or an acknowledge stays visible indefinitely, because level changes never clear an edge latch. For that reason the bench reads status after every stimulus step and compares the result with a model built from the trigger rules. A masked latch is hidden, so the bench unmasks pins at random to bring such state back to the ports.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_TYPE   = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_POL    = 8'h3c;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 8'h4c;

  // {type, polarity}
  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW  = 2'b00,
    TRIG_LEVEL_HIGH = 2'b01,
    TRIG_EDGE_FALL  = 2'b10,
    TRIG_EDGE_RISE  = 2'b11
  } trig_e;

endpackage

// File: rtl/gpirq_rstsync.sv
module gpirq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] din,
  output logic [NPIN-1:0] lvl,
  output logic [NPIN-1:0] rise,
  output logic [NPIN-1:0] fall
);

  logic [NPIN-1:0] meta_q;
  logic [NPIN-1:0] sync_q;
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    lvl  = sync_q;
    rise = sync_q & ~prev_q;
    fall = ~sync_q & prev_q;
  end

endmodule

// File: rtl/gpirq_cell.sv
module gpirq_cell
  import gpirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic typ,
  input  logic pol,
  input  logic lvl,
  input  logic rise,
  input  logic fall,
  input  logic ack,
  output logic latch_q,
  output logic pend
);

  trig_e mode;
  logic  hit;
  logic  lvl_act;
  logic  latch_d;
  logic  latch_ce;

  always_comb begin
    mode    = trig_e'({typ, pol});
    hit     = 1'b0;
    lvl_act = 1'b0;
    unique case (mode)
      TRIG_LEVEL_LOW:  lvl_act = ~lvl;
      TRIG_LEVEL_HIGH: lvl_act = lvl;
      TRIG_EDGE_FALL:  hit     = fall;
      TRIG_EDGE_RISE:  hit     = rise;
      default:         hit     = 1'b0;
    endcase
  end

  // A new event wins over an acknowledge in the same cycle.
  always_comb begin
    latch_d = latch_q;
    if (!en || !typ) begin
      latch_d = 1'b0;
    end else if (hit) begin
      latch_d = 1'b1;
    end else if (ack) begin
      latch_d = 1'b0;
    end
    latch_ce = (latch_d != latch_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (latch_ce) begin
      latch_q <= latch_d;
    end
  end

  always_comb begin
    pend = typ ? latch_q : (en & lvl_act);
  end

endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs
  import gpirq_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [NPIN-1:0]   status,
  output logic [DATA_W-1:0] prdata,
  output logic [NPIN-1:0]   en_q,
  output logic [NPIN-1:0]   msk_q,
  output logic [NPIN-1:0]   typ_q,
  output logic [NPIN-1:0]   pol_q,
  output logic [NPIN-1:0]   ack
);

  logic            wr;
  logic            rd;
  logic [NPIN-1:0] wbits;
  logic            en_we, msk_we, typ_we, pol_we;
  logic [NPIN-1:0] en_d, msk_d, typ_d, pol_d;

  always_comb begin
    wr     = psel & penable & pwrite;
    rd     = psel & ~pwrite;
    wbits  = pwdata[NPIN-1:0];
    en_we  = wr && (paddr == OFF_ENABLE);
    msk_we = wr && (paddr == OFF_MASK);
    typ_we = wr && (paddr == OFF_TYPE);
    pol_we = wr && (paddr == OFF_POL);
    en_d   = wbits;
    msk_d  = wbits;
    typ_d  = wbits;
    pol_d  = wbits;
    ack    = (wr && (paddr == OFF_ACK)) ? wbits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= '0;
    end else if (msk_we) begin
      msk_q <= msk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q <= '0;
    end else if (typ_we) begin
      typ_q <= typ_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
    end else if (pol_we) begin
      pol_q <= pol_d;
    end
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      unique case (paddr)
        OFF_ENABLE: prdata[NPIN-1:0] = en_q;
        OFF_MASK:   prdata[NPIN-1:0] = msk_q;
        OFF_TYPE:   prdata[NPIN-1:0] = typ_q;
        OFF_POL:    prdata[NPIN-1:0] = pol_q;
        OFF_STATUS: prdata[NPIN-1:0] = status;
        default:    prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpirq_top.sv
module gpirq_top
  import gpirq_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic              irq_out
);

  logic            rst_core_n;
  logic [NPIN-1:0] lvl, rise, fall;
  logic [NPIN-1:0] en_q, msk_q, typ_q, pol_q, ack;
  logic [NPIN-1:0] latch_q, pend, status;

  gpirq_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  gpirq_sync #(.NPIN(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (pin_in),
    .lvl   (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  gpirq_regs #(.NPIN(NPIN), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .status  (status),
    .prdata  (prdata),
    .en_q    (en_q),
    .msk_q   (msk_q),
    .typ_q   (typ_q),
    .pol_q   (pol_q),
    .ack     (ack)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpirq_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .en      (en_q[i]),
      .typ     (typ_q[i]),
      .pol     (pol_q[i]),
      .lvl     (lvl[i]),
      .rise    (rise[i]),
      .fall    (fall[i]),
      .ack     (ack[i]),
      .latch_q (latch_q[i]),
      .pend    (pend[i])
    );
  end

  always_comb begin
    status  = pend & en_q & ~msk_q;
    irq_out = |status;
  end

endmodule

// File: rtl/gpirq_chk.sv
module gpirq_chk
  import gpirq_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] prdata,
  input logic              irq_out,
  input logic [NPIN-1:0]   en_q,
  input logic [NPIN-1:0]   typ_q,
  input logic [NPIN-1:0]   latch_q,
  input logic [NPIN-1:0]   ack
);

  logic known_off;
  assign known_off = (paddr == OFF_ENABLE) || (paddr == OFF_MASK) ||
                     (paddr == OFF_TYPE)   || (paddr == OFF_POL)  ||
                     (paddr == OFF_STATUS);

  assert_irq_low_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !irq_out);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prdata[DATA_W-1:NPIN] == '0);

  assert_latch_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(latch_q & en_q & typ_q & ~ack)) ==
              $past(latch_q & en_q & typ_q & ~ack)));

  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_q & ~en_q) != '0) |=> ((latch_q & ~$past(en_q)) == '0));

  assert_status_matches_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == OFF_STATUS) |-> ((prdata != '0) == irq_out));

  assert_undefined_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && !known_off) |-> (prdata == '0));

endmodule

bind gpirq_top gpirq_chk #(.NPIN(NPIN), .DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .psel    (psel),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .prdata  (prdata),
  .irq_out (irq_out),
  .en_q    (en_q),
  .typ_q   (typ_q),
  .latch_q (latch_q),
  .ack     (ack)
);

// File: tb/gpirq_top_tb_top.sv
module gpirq_top_tb_top;

  localparam int NPIN = 8;
  localparam int DW   = 32;

  logic          clk;
  logic          rst_n;
  logic          psel, penable, pwrite;
  logic [7:0]    paddr;
  logic [DW-1:0] pwdata;
  logic [DW-1:0] prdata;
  logic [NPIN-1:0] pin_in;
  logic          irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [NPIN-1:0] m_en, m_msk, m_typ, m_pol, m_pend, m_pin;

  gpirq_top #(.NPIN(NPIN), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [NPIN-1:0] exp_status();
    logic [NPIN-1:0] lv;
    lv = (m_pol & m_pin) | (~m_pol & ~m_pin);
    return ((m_typ & m_pend) | (~m_typ & lv)) & m_en & ~m_msk;
  endfunction

  function automatic logic [DW-1:0] exp_reg(input logic [7:0] a);
    logic [DW-1:0] r;
    r = '0;
    case (a)
      8'h30: r[NPIN-1:0] = m_en;
      8'h34: r[NPIN-1:0] = m_msk;
      8'h38: r[NPIN-1:0] = m_typ;
      8'h3c: r[NPIN-1:0] = m_pol;
      8'h40: r[NPIN-1:0] = exp_status();
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic compare(input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [DW-1:0] d);
    logic [NPIN-1:0] b;
    b = d[NPIN-1:0];
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    case (a)
      8'h30: begin m_en  = b; m_pend &= b; end
      8'h34: m_msk = b;
      8'h38: begin m_typ = b; m_pend &= b; end
      8'h3c: m_pol = b;
      8'h4c: m_pend &= ~b;
      default: ;
    endcase
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    #1 d = prdata;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic set_pins(input logic [NPIN-1:0] v);
    logic [NPIN-1:0] rs, fl;
    @(negedge clk);
    rs = v & ~m_pin;
    fl = ~v & m_pin;
    pin_in = v;
    m_pend |= m_en & m_typ & ((m_pol & rs) | (~m_pol & fl));
    m_pin = v;
  endtask

  task automatic check_stat(input string tag);
    logic [DW-1:0] d;
    repeat (4) @(negedge clk);
    compare({tag, " irq_out"}, {31'b0, irq_out}, {31'b0, |exp_status()});
    apb_rd(8'h40, d);
    compare({tag, " status"}, d, exp_reg(8'h40));
  endtask

  task automatic check_reg(input string tag, input logic [7:0] a);
    logic [DW-1:0] d;
    apb_rd(a, d);
    compare(tag, d, exp_reg(a));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [DW-1:0] d;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    pin_in = '0; rst_n = 1'b0;
    m_en = '0; m_msk = '0; m_typ = '0; m_pol = '0; m_pend = '0; m_pin = '0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    compare("R1 irq in reset", {31'b0, irq_out}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_reg("R1 enable", 8'h30);
    check_reg("R1 mask", 8'h34);
    check_reg("R1 type", 8'h38);
    check_reg("R1 polarity", 8'h3c);
    check_stat("R1");

    // R2 read/write with upper bits
    apb_wr(8'h34, 32'hFFFF_FF5A);
    check_reg("R2 mask rw", 8'h34);
    apb_wr(8'h34, 32'h0);
    apb_wr(8'h3c, 32'hA5A5_A5C3);
    check_reg("R2 polarity rw", 8'h3c);

    // R3 rising and falling edges
    apb_wr(8'h38, 32'h0F);
    apb_wr(8'h3c, 32'h05);
    apb_wr(8'h30, 32'h0F);
    set_pins(8'h0F);
    check_stat("R3 rising edges");
    set_pins(8'h00);
    check_stat("R3 falling edges sticky");

    // R5 acknowledge
    apb_wr(8'h4c, 32'h00);
    check_stat("R5 ack zero no effect");
    apb_wr(8'h4c, 32'h01);
    check_stat("R5 ack one clears");
    check_reg("R5 ack reads zero", 8'h4c);
    apb_wr(8'h4c, 32'hFF);

    // R4 level modes
    apb_wr(8'h30, 32'hF0);
    apb_wr(8'h3c, 32'h30);
    set_pins(8'h50);
    check_stat("R4 level mixed");
    apb_wr(8'h4c, 32'hF0);
    check_stat("R4 ack ignored on level");
    set_pins(8'hA0);
    check_stat("R4 level follows");

    // R6 disable clears and blocks
    apb_wr(8'h30, 32'h0F);
    set_pins(8'hAF);
    check_stat("R6 before disable");
    apb_wr(8'h30, 32'h00);
    set_pins(8'hA0);
    apb_wr(8'h30, 32'h0F);
    check_stat("R6 cleared and not recorded");

    // R7 mask keeps pending
    set_pins(8'hAF);
    apb_wr(8'h34, 32'h0F);
    check_stat("R7 masked hidden");
    apb_wr(8'h34, 32'h00);
    check_stat("R7 unmask reveals");

    // R10 type switch to level discards latch
    apb_wr(8'h38, 32'h00);
    apb_wr(8'h38, 32'h0F);
    check_stat("R10 latch discarded");

    // R9 undefined and status writes ignored
    apb_wr(8'h40, 32'hFF);
    apb_wr(8'h44, 32'hFF);
    apb_wr(8'h00, 32'hFF);
    check_reg("R9 undefined 0x44", 8'h44);
    check_reg("R9 undefined 0x00", 8'h00);
    check_reg("R9 enable unchanged", 8'h30);
    check_stat("R9 status unchanged");

    // R8 random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [7:0] a;
      op = $urandom % 10;
      case (op)
        0, 1: set_pins(NPIN'($urandom));
        2: apb_wr(8'h30, $urandom);
        3: apb_wr(8'h34, ($urandom % 3 == 0) ? $urandom : 32'h0);
        4: apb_wr(8'h38, $urandom);
        5: apb_wr(8'h3c, $urandom);
        6: apb_wr(8'h4c, $urandom);
        7: apb_wr((($urandom % 2) == 0) ? 8'h40 : 8'h48, $urandom);
        8: begin
          a = 8'h30 + 8'(4 * ($urandom % 8));
          check_reg("R2 R9 random read", a);
        end
        default: set_pins(m_pin ^ (NPIN'(1) << ($urandom % NPIN)));
      endcase
      check_stat("R8 random");
    end

    done = 1;
    summary();
  end

endmodule